// File: doc/BRIEF.md
# Fault-history and triggered-observation capture unit

This block records a multi-channel stream of controller samples into two capture memories with opposite trigger behaviour. The history buffer runs freely from reset. It overwrites its oldest entry on every valid sample. A fault trigger freezes it, so it keeps the samples that led up to the fault. The observation buffer waits until it is armed and then triggered. After that it keeps one sample out of every `obs_div`+1 valid samples until it is full.

A stimulus memory is tied to the observation capture. Software loads it with a waveform such as a step, a sine or a noise sequence. The stored entries appear on the stimulus output one by one, each in step with a stored observation sample. A measured response can therefore be lined up with the excitation that caused it. Both buffers are read through one combinational port. The history buffer is addressed by age, with index 0 holding the oldest sample.

Top module: `diag_capture`

## Requirements
- R1: After reset the history buffer is running (`pm_armed`=1, `pm_frozen`=0, `pm_full`=0). The observation buffer is idle (`obs_armed`=0, `obs_busy`=0, `obs_full`=0). `exc_active`=0 and `exc_out`=0.
- R2: While the history buffer runs, every valid sample is written at the next circular address. `pm_full` rises once the address wraps past the last entry.
- R3: A `pm_trig` pulse while running sets `pm_frozen` and clears `pm_armed`. Later samples are not written. A `pm_trig` while frozen has no effect.
- R4: With `rd_sel`=0, `rd_data` is the history entry of age `rd_idx`. Index 0 is the oldest held sample: the first sample written if the buffer never wrapped, otherwise the entry at the frozen write address.
- R5: A `pm_rearm` pulse clears the freeze, clears `pm_full` and restarts writing from address 0.
- R6: An `obs_arm` pulse sets `obs_armed` and clears `obs_full` and the fill count. An `obs_trig` while armed clears `obs_armed` and sets `obs_busy`. An `obs_trig` while not armed is ignored.
- R7: While `obs_busy`, the first valid sample is stored. After that one valid sample in every `obs_div`+1 is stored, in order, at indices 0, 1, 2, and so on. With `rd_sel`=1, `rd_data` is the entry at `rd_idx`.
- R8: When the last observation entry is stored, `obs_busy` clears and `obs_full` sets. Further samples are not stored.
- R9: A write with `exc_we` stores `exc_wdata` at `exc_addr` in the stimulus memory.
- R10: From the clock edge that stores observation sample k until the edge that stores the next one, `exc_active`=1 and `exc_out` equals stimulus entry k. At the edge that fills the buffer, and at all other times, `exc_active`=0 and `exc_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | CH*DW | Channels packed, channel 0 in the low bits |
| pm_trig | input | 1 | Fault trigger for the history buffer |
| pm_rearm | input | 1 | Restart history capture |
| obs_arm | input | 1 | Arm the observation buffer |
| obs_trig | input | 1 | Start observation capture |
| obs_div | input | 16 | Decimation: keep 1 in obs_div+1 samples |
| exc_we | input | 1 | Stimulus memory write enable |
| exc_addr | input | AW | Stimulus write address |
| exc_wdata | input | EW | Stimulus write data |
| rd_sel | input | 1 | Readout source: 0 history, 1 observation |
| rd_idx | input | AW | Readout index |
| rd_data | output | CH*DW | Readout data |
| exc_out | output | EW | Stimulus output |
| exc_active | output | 1 | Stimulus playback in progress |
| pm_armed | output | 1 | History buffer running |
| pm_frozen | output | 1 | History buffer frozen by a trigger |
| pm_full | output | 1 | History buffer has wrapped |
| obs_armed | output | 1 | Observation buffer waiting for a trigger |
| obs_busy | output | 1 | Observation capture in progress |
| obs_full | output | 1 | Observation buffer complete |

## Verification
The hardest state to reach is a history buffer that has wrapped an uneven number of entries and then frozen. Only in that state does the age-to-address remapping show, and most capture lengths hide it. The stimulus re-arms the buffer and writes 20 known samples into 16 entries. It fires the trigger in a cycle with no valid sample, then keeps feeding samples that must not land. The oldest and newest readouts then pin down both the remap and the freeze. The stimulus-to-response alignment is reached by loading distinct stimulus values and sampling `exc_out` right after the first stored observation sample, under several decimation settings.

// File: rtl/diag_capture.sv
module diag_capture #(
  parameter int CH = 2,
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int EW = 8,
  localparam int SW = CH * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_data,
  input  logic          pm_trig,
  input  logic          pm_rearm,
  input  logic          obs_arm,
  input  logic          obs_trig,
  input  logic [15:0]   obs_div,
  input  logic          exc_we,
  input  logic [AW-1:0] exc_addr,
  input  logic [EW-1:0] exc_wdata,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_idx,
  output logic [SW-1:0] rd_data,
  output logic [EW-1:0] exc_out,
  output logic          exc_active,
  output logic          pm_armed,
  output logic          pm_frozen,
  output logic          pm_full,
  output logic          obs_armed,
  output logic          obs_busy,
  output logic          obs_full
);
  localparam int DEPTH = 1 << AW;

  logic [SW-1:0] pm_mem  [DEPTH];
  logic [SW-1:0] obs_mem [DEPTH];
  logic [EW-1:0] exc_mem [DEPTH];

  logic [AW-1:0] pm_wp, obs_wp, pm_addr;
  logic [15:0]   dcnt;
  logic          pm_wr, obs_take;

  assign pm_wr    = pm_armed && smp_valid && !pm_rearm;
  assign obs_take = obs_busy && smp_valid && (dcnt == 16'd0) && !obs_arm;

  // history buffer control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_armed  <= 1'b1;
      pm_frozen <= 1'b0;
      pm_full   <= 1'b0;
      pm_wp     <= '0;
    end else if (pm_rearm) begin
      pm_armed  <= 1'b1;
      pm_frozen <= 1'b0;
      pm_full   <= 1'b0;
      pm_wp     <= '0;
    end else begin
      if (pm_wr) begin
        pm_wp <= pm_wp + 1'b1;
        if (pm_wp == '1) pm_full <= 1'b1;
      end
      if (pm_armed && pm_trig) begin
        pm_armed  <= 1'b0;
        pm_frozen <= 1'b1;
      end
    end
  end

  // observation buffer control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obs_armed <= 1'b0;
      obs_busy  <= 1'b0;
      obs_full  <= 1'b0;
      obs_wp    <= '0;
      dcnt      <= '0;
    end else if (obs_arm) begin
      obs_armed <= 1'b1;
      obs_busy  <= 1'b0;
      obs_full  <= 1'b0;
      obs_wp    <= '0;
      dcnt      <= '0;
    end else begin
      if (obs_armed && obs_trig) begin
        obs_armed <= 1'b0;
        obs_busy  <= 1'b1;
        dcnt      <= '0;
      end
      if (obs_busy && smp_valid) begin
        dcnt <= (dcnt == obs_div) ? 16'd0 : dcnt + 16'd1;
        if (dcnt == 16'd0) begin
          obs_wp <= obs_wp + 1'b1;
          if (obs_wp == '1) begin
            obs_full <= 1'b1;
            obs_busy <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pm_wr)    pm_mem[pm_wp]   <= smp_data;
    if (obs_take) obs_mem[obs_wp] <= smp_data;
    if (exc_we)   exc_mem[exc_addr] <= exc_wdata;
  end

  assign exc_active = obs_busy && (obs_wp != '0);
  assign exc_out    = exc_active ? exc_mem[obs_wp - 1'b1] : '0;

  assign pm_addr = pm_full ? pm_wp + rd_idx : rd_idx;
  assign rd_data = rd_sel ? obs_mem[rd_idx] : pm_mem[pm_addr];

  assert_pm_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pm_armed && smp_valid && !pm_rearm |=> pm_wp == $past(pm_wp) + 1'b1);

  assert_freeze_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pm_frozen && !pm_rearm |=> pm_frozen && $stable(pm_wp));

  assert_idle_trig_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !obs_armed && !obs_busy && !obs_arm |=> !obs_busy);

  assert_decimate_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    obs_busy && smp_valid && dcnt != 16'd0 && !obs_arm |=> $stable(obs_wp));

  assert_full_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    obs_full && !obs_arm |=> obs_full && !obs_busy);

  assert_play_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obs_full) |-> !exc_active);
endmodule

// File: tb/diag_capture_tb.sv
module diag_capture_tb;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, pm_trig = 0, pm_rearm = 0, obs_arm = 0, obs_trig = 0;
  logic [15:0] smp_data = 0, obs_div = 0;
  logic exc_we = 0, rd_sel = 0;
  logic [AW-1:0] exc_addr = 0, rd_idx = 0;
  logic [7:0] exc_wdata = 0, exc_out;
  logic [15:0] rd_data;
  logic exc_active, pm_armed, pm_frozen, pm_full, obs_armed, obs_busy, obs_full;
  int total = 0, bad = 0;

  // decimation, expected entry at index 1, expected entry at index 3
  localparam logic [15:0] VEC [4][3] = '{
    '{16'd0, 16'd1, 16'd3},
    '{16'd1, 16'd2, 16'd6},
    '{16'd2, 16'd3, 16'd9},
    '{16'd4, 16'd5, 16'd15}};

  always #5 clk = ~clk;

  diag_capture #(.CH(2), .DW(8), .AW(AW), .EW(8)) u_dut (
    .clk, .rst_n, .smp_valid, .smp_data, .pm_trig, .pm_rearm, .obs_arm,
    .obs_trig, .obs_div, .exc_we, .exc_addr, .exc_wdata, .rd_sel, .rd_idx,
    .rd_data, .exc_out, .exc_active, .pm_armed, .pm_frozen, .pm_full,
    .obs_armed, .obs_busy, .obs_full);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [7:0] d);
    smp_valid = v; smp_data = {d, d};
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic pulse_pm_trig();   pm_trig = 1;  @(negedge clk); pm_trig = 0;  endtask
  task automatic pulse_pm_rearm();  pm_rearm = 1; @(negedge clk); pm_rearm = 0; endtask
  task automatic pulse_obs_arm();   obs_arm = 1;  @(negedge clk); obs_arm = 0;  endtask
  task automatic pulse_obs_trig();  obs_trig = 1; @(negedge clk); obs_trig = 0; endtask

  task automatic rd(input logic s, input int i, output logic [15:0] v);
    rd_sel = s; rd_idx = i[AW-1:0]; #1; v = rd_data;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 pm_armed", pm_armed, 1);
    chk("R1 pm_frozen", pm_frozen, 0);
    chk("R1 pm_full", pm_full, 0);
    chk("R1 obs_armed", obs_armed, 0);
    chk("R1 obs_busy", obs_busy, 0);
    chk("R1 obs_full", obs_full, 0);
    chk("R1 exc_active", exc_active, 0);
    chk("R1 exc_out", exc_out, 0);

    // R9 load stimulus: entry k = 3k+1
    for (int k = 0; k < D; k++) begin
      exc_we = 1; exc_addr = k[AW-1:0]; exc_wdata = 8'(3 * k + 1);
      @(negedge clk);
    end
    exc_we = 0;
    chk("R10 idle exc_out", exc_out, 0);

    // table walk: decimated observation capture with playback
    for (int t = 0; t < 4; t++) begin
      obs_div = VEC[t][0];
      pulse_obs_arm();
      chk("R6 armed", obs_armed, 1);
      pulse_obs_trig();
      chk("R6 busy", obs_busy, 1);
      chk("R6 armed cleared", obs_armed, 0);
      for (int n = 0; n <= (D - 1) * (VEC[t][0] + 1); n++) begin
        cyc(1, n[7:0]);
        if (n == 0) begin
          chk("R10 exc_active first", exc_active, 1);
          chk("R9 R10 exc_out first", exc_out, 1);
        end
      end
      chk("R8 full", obs_full, 1);
      chk("R8 busy cleared", obs_busy, 0);
      chk("R10 stopped", exc_active, 0);
      chk("R10 out zero", exc_out, 0);
      cyc(1, 8'hEE);
      rd(1, 0, v); chk("R7 idx0", v, 0);
      rd(1, 1, v); chk("R7 idx1", v, {VEC[t][1][7:0], VEC[t][1][7:0]});
      rd(1, 3, v); chk("R7 idx3", v, {VEC[t][2][7:0], VEC[t][2][7:0]});
      rd(1, D - 1, v);
      chk("R8 last entry kept", v, {8'(15 * (VEC[t][0] + 1)), 8'(15 * (VEC[t][0] + 1))});
    end

    // R6 trigger while not armed is ignored
    pulse_obs_trig();
    cyc(1, 8'h77); cyc(1, 8'h78);
    chk("R6 ignored busy", obs_busy, 0);
    chk("R6 ignored full", obs_full, 1);
    rd(1, 1, v); chk("R6 ignored data", v, 16'h0505);

    // R2 R3 R4 R5 wrapped history then freeze
    pulse_pm_rearm();
    chk("R5 rearm armed", pm_armed, 1);
    chk("R5 rearm full", pm_full, 0);
    for (int n = 0; n < 20; n++) cyc(1, 8'(100 + n));
    chk("R2 wrapped", pm_full, 1);
    pulse_pm_trig();
    chk("R3 frozen", pm_frozen, 1);
    chk("R3 armed low", pm_armed, 0);
    for (int n = 0; n < 3; n++) cyc(1, 8'(200 + n));
    pulse_pm_trig();
    chk("R3 still frozen", pm_frozen, 1);
    rd(0, 0, v);  chk("R4 oldest", v, {8'd104, 8'd104});
    rd(0, 15, v); chk("R3 R4 newest", v, {8'd119, 8'd119});

    // R5 rearm restarts at address 0, partial fill
    pulse_pm_rearm();
    chk("R5 unfrozen", pm_frozen, 0);
    for (int n = 0; n < 5; n++) cyc(1, 8'(50 + n));
    pulse_pm_trig();
    chk("R2 not wrapped", pm_full, 0);
    rd(0, 0, v); chk("R4 R5 first", v, {8'd50, 8'd50});
    rd(0, 4, v); chk("R4 fifth", v, {8'd54, 8'd54});

    finish_run();
  end
endmodule